// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block holds the single reservation that a one-core processor needs for its atomic load-and-reserve and conditional-store word operations. The load/store unit presents one request per cycle. Each request gives an operation code, an access size, an effective address, the byte-order mode, and the cacheability and miss status of the access. The monitor checks alignment and records the reserved line. It answers every conditional store with a one-cycle pass/fail response. For reserved accesses that must go to a bus, it also forms the bus request and its reservation attribute.

The reservation is lost in two ways. The first is a write on the on-chip bus by the communication master that hits the reserved line. The second is a pulse on either of two cancel inputs, which stand in for every agent outside the chip. No activity on the external bus is observed. All responses are registered and appear in the cycle after the request.

Top module: `resv_monitor`

## Requirements
- R1: After reset, resvValid, scDone, scSuccess, alignExc, busReq and busAttr are all 0.
- R2: A load-reserve (reqOp = 2) whose address has bits [1:0] = 0 sets resvValid in the next cycle. It records the 16-byte line address (address bits above bit 3) and replaces any older reservation.
- R3: A load-reserve or conditional store (reqOp = 3) whose address bits [1:0] are not 0 raises alignExc for one cycle in the next cycle. It leaves resvValid and the recorded line unchanged and produces no scDone.
- R4: An aligned conditional store gives scDone = 1 in the next cycle. scSuccess is 1 only if the reservation was valid and its line equals the store's line. The reservation is cleared whether the store passes or fails.
- R5: A 1 on cancelA or cancelB clears the reservation in the next cycle. The one exception is an aligned load-reserve in the same cycle, which establishes the new reservation.
- R6: A snoop with snoopValid, snoopWrite and snoopFromComm all 1, whose line equals the reserved line, clears the reservation. A snoop read, a write from another master, or a write to another line leaves it intact.
- R7: When a cancel or a matching snoop write arrives in the same cycle as an aligned conditional store, the store fails.
- R8: In little-endian mode (reqLittle = 1), a plain load (reqOp = 0) or store (reqOp = 1) raises alignExc when it is misaligned for its size. Sizes are 0 byte, 1 half, 2 word and 3 doubleword. In big-endian mode these accesses never raise alignExc.
- R9: In little-endian mode, a multiple or string access (reqOp = 4) always raises alignExc. In big-endian mode it never does.
- R10: An aligned reserved access that misses or is uncacheable gives busReq = 1 in the next cycle. busAttr equals !reqCacheable, so a cacheable miss carries no reservation attribute. No other request drives busReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 3 | 0 load, 1 store, 2 load-reserve, 3 conditional store, 4 multiple/string |
| reqSize | input | 2 | Scalar size: 0 byte, 1 half, 2 word, 3 doubleword |
| reqAddr | input | ADDR_W | Effective address |
| reqLittle | input | 1 | Little-endian mode |
| reqCacheable | input | 1 | Access targets a cacheable region |
| reqMiss | input | 1 | Access missed in the data cache |
| snoopValid | input | 1 | On-chip bus transfer present |
| snoopWrite | input | 1 | On-chip transfer is a write |
| snoopFromComm | input | 1 | Transfer issued by the communication master |
| snoopAddr | input | ADDR_W | On-chip transfer address |
| cancelA | input | 1 | External reservation cancel, first pin |
| cancelB | input | 1 | External reservation cancel, second pin |
| resvValid | output | 1 | Reservation currently held |
| scDone | output | 1 | Conditional-store response strobe |
| scSuccess | output | 1 | Conditional store passed |
| alignExc | output | 1 | Alignment exception request |
| busReq | output | 1 | Reserved access issues a bus request |
| busAttr | output | 1 | Reservation attribute on that bus request |

## Verification
The bench issues a load-reserve at every address of an 8-bit space, each followed by a conditional store. The stores alternate between the reserved line and a neighbouring line, which separates the alignment faults, a matching store and a mismatching one. A sweep over every size, low address offset and byte order for plain accesses and multiple accesses checks the little-endian fault rules against the big-endian ones. Directed patterns drive each cancel pin and the kinds of snoop traffic that must not clear the reservation, and place a kill on the same cycle as a store, to show that the clear takes priority. A walk over the cacheable and miss flags checks when a bus request is issued and whether it carries the attribute.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_LRSV  = 3'd2,
    OP_SCOND = 3'd3,
    OP_MULTI = 3'd4
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setResv;    // aligned load-reserve: capture line
    logic scAttempt;  // aligned conditional store: consume reservation
  } ctrl_strobe_t;

endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [2:0]   reqOp,
  input  logic [1:0]   reqSize,
  input  logic [2:0]   addrLow,
  input  logic         reqLittle,
  input  logic         reqCacheable,
  input  logic         reqMiss,
  input  logic         scPass,
  output ctrl_strobe_t strobe,
  output logic         scDone,
  output logic         scSuccess,
  output logic         alignExc,
  output logic         busReq,
  output logic         busAttr
);

  logic isLr, isSc, isScalar, isMulti, isReserved;
  logic wordMis, scalarMis, alignFault, busIssue;

  assign isLr       = reqValid && (reqOp == OP_LRSV);
  assign isSc       = reqValid && (reqOp == OP_SCOND);
  assign isScalar   = reqValid && ((reqOp == OP_LOAD) || (reqOp == OP_STORE));
  assign isMulti    = reqValid && (reqOp == OP_MULTI);
  assign isReserved = isLr || isSc;

  assign wordMis = |addrLow[1:0];

  always_comb begin
    case (reqSize)
      2'd0:    scalarMis = 1'b0;
      2'd1:    scalarMis = addrLow[0];
      2'd2:    scalarMis = |addrLow[1:0];
      default: scalarMis = |addrLow;
    endcase
  end

  // reserved ops fault in either byte order; little-endian adds scalar and multi rules
  assign alignFault = (isReserved && wordMis)
                    || (reqLittle && isMulti)
                    || (reqLittle && isScalar && scalarMis);

  always_comb begin
    strobe           = '0;
    strobe.setResv   = isLr && !wordMis;
    strobe.scAttempt = isSc && !wordMis;
  end

  assign busIssue = (strobe.setResv || strobe.scAttempt) && (reqMiss || !reqCacheable);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scDone    <= 1'b0;
      scSuccess <= 1'b0;
      alignExc  <= 1'b0;
      busReq    <= 1'b0;
      busAttr   <= 1'b0;
    end else begin
      scDone    <= strobe.scAttempt;
      scSuccess <= strobe.scAttempt && scPass;
      alignExc  <= alignFault;
      busReq    <= busIssue;
      // cacheable misses never carry the reservation attribute
      busAttr   <= busIssue && !reqCacheable;
    end
  end

endmodule

// File: rtl/resv_dpath.sv
module resv_dpath
  import resv_pkg::*;
#(
  parameter int LINE_W = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              snoopValid,
  input  logic              snoopWrite,
  input  logic              snoopFromComm,
  input  logic [LINE_W-1:0] snoopLine,
  input  logic              cancelA,
  input  logic              cancelB,
  output logic              resvValid,
  output logic              scPass
);

  logic [LINE_W-1:0] resvLine;
  logic              reqHit, snoopHit, killResv;

  assign reqHit   = (reqLine == resvLine);
  assign snoopHit = snoopValid && snoopWrite && snoopFromComm && (snoopLine == resvLine);
  assign killResv = cancelA || cancelB || (resvValid && snoopHit);

  // a kill in the same cycle wins over the store
  assign scPass = resvValid && reqHit && !killResv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resvValid <= 1'b0;
      resvLine  <= '0;
    end else if (strobe.setResv) begin
      resvValid <= 1'b1;
      resvLine  <= reqLine;
    end else if (strobe.scAttempt || killResv) begin
      resvValid <= 1'b0;
    end
  end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqLittle,
  input  logic              reqCacheable,
  input  logic              reqMiss,
  input  logic              snoopValid,
  input  logic              snoopWrite,
  input  logic              snoopFromComm,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              cancelA,
  input  logic              cancelB,
  output logic              resvValid,
  output logic              scDone,
  output logic              scSuccess,
  output logic              alignExc,
  output logic              busReq,
  output logic              busAttr
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;

  ctrl_strobe_t strobe;
  logic         scPass;

  resv_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqOp        (reqOp),
    .reqSize      (reqSize),
    .addrLow      (reqAddr[2:0]),
    .reqLittle    (reqLittle),
    .reqCacheable (reqCacheable),
    .reqMiss      (reqMiss),
    .scPass       (scPass),
    .strobe       (strobe),
    .scDone       (scDone),
    .scSuccess    (scSuccess),
    .alignExc     (alignExc),
    .busReq       (busReq),
    .busAttr      (busAttr)
  );

  resv_dpath #(.LINE_W(LINE_W)) uDpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqLine       (reqAddr[ADDR_W-1:OFF_W]),
    .snoopValid    (snoopValid),
    .snoopWrite    (snoopWrite),
    .snoopFromComm (snoopFromComm),
    .snoopLine     (snoopAddr[ADDR_W-1:OFF_W]),
    .cancelA       (cancelA),
    .cancelB       (cancelB),
    .resvValid     (resvValid),
    .scPass        (scPass)
  );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqLittle,
  input logic              cancelA,
  input logic              cancelB,
  input logic              resvValid,
  input logic              scDone,
  input logic              scSuccess,
  input logic              alignExc,
  input logic              busReq,
  input logic              busAttr
);

  logic lrReq, scReq, lowBad;
  assign lrReq  = reqValid && (reqOp == OP_LRSV);
  assign scReq  = reqValid && (reqOp == OP_SCOND);
  assign lowBad = (reqAddr[1:0] != 2'b00);

  // R2
  lr_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    lrReq && !lowBad |=> resvValid);

  // R3
  resv_misalign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lrReq || scReq) && lowBad |=> alignExc && !scDone && (resvValid == $past(resvValid)));

  // R4
  sc_consumes_chk: assert property (@(posedge clk) disable iff (!rstN)
    scReq && !lowBad |=> scDone && !resvValid);

  // R4
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    scSuccess |-> scDone);

  // R5
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cancelA || cancelB) && !(lrReq && !lowBad) |=> !resvValid);

  // R7
  cancel_fails_sc_chk: assert property (@(posedge clk) disable iff (!rstN)
    scReq && (cancelA || cancelB) |=> !scSuccess);

  // R9
  le_multi_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqLittle && (reqOp == OP_MULTI) |=> alignExc);

  // R10
  attr_with_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    busAttr |-> busReq);

endmodule

bind resv_monitor resv_monitor_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqOp     (reqOp),
  .reqAddr   (reqAddr),
  .reqLittle (reqLittle),
  .cancelA   (cancelA),
  .cancelB   (cancelB),
  .resvValid (resvValid),
  .scDone    (scDone),
  .scSuccess (scSuccess),
  .alignExc  (alignExc),
  .busReq    (busReq),
  .busAttr   (busAttr)
);

// File: tb/sim_resv_monitor.sv
`timescale 1ns/1ps
module sim_resv_monitor;

  localparam int AW = 8;
  localparam int LB = 16;
  localparam int NOP = 7;  // bench-only marker: no request this cycle

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid, reqLittle, reqCacheable, reqMiss;
  logic [2:0]    reqOp;
  logic [1:0]    reqSize;
  logic [AW-1:0] reqAddr, snoopAddr;
  logic          snoopValid, snoopWrite, snoopFromComm, cancelA, cancelB;
  logic          resvValid, scDone, scSuccess, alignExc, busReq, busAttr;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  bit mValid = 1'b0;
  int mLine  = 0;

  always #2.5 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .LINE_BYTES(LB)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqLittle(reqLittle), .reqCacheable(reqCacheable), .reqMiss(reqMiss),
    .snoopValid(snoopValid), .snoopWrite(snoopWrite), .snoopFromComm(snoopFromComm),
    .snoopAddr(snoopAddr), .cancelA(cancelA), .cancelB(cancelB), .resvValid(resvValid),
    .scDone(scDone), .scSuccess(scSuccess), .alignExc(alignExc), .busReq(busReq), .busAttr(busAttr)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d exp %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; reqOp = 0; reqSize = 0; reqAddr = 0; reqLittle = 0;
    reqCacheable = 1; reqMiss = 0; snoopValid = 0; snoopWrite = 0;
    snoopFromComm = 0; snoopAddr = 0; cancelA = 0; cancelB = 0;
  endtask

  // one request cycle with a reference model computed from the requirements
  task automatic doOp(input string tag, input int op, input int size, input int addr,
                      input bit le, input bit cach, input bit miss, input bit ca, input bit cb,
                      input bit sv, input bit sw, input bit sc, input int saddr);
    bit isRes, mis, fault, kill, lrOk, scOk, eDone, ePass, eBus, eAttr;
    int mask;
    isRes = (op == 2) || (op == 3);
    mask  = (size == 0) ? 0 : (size == 1) ? 1 : (size == 2) ? 3 : 7;
    mis   = isRes ? ((addr % 4) != 0) : ((addr & mask) != 0);
    fault = (isRes && mis) || (le && op == 4) || (le && (op == 0 || op == 1) && mis);
    kill  = ca || cb || (sv && sw && sc && mValid && (saddr / LB) == mLine);
    lrOk  = (op == 2) && !mis;
    scOk  = (op == 3) && !mis;
    eDone = scOk;
    ePass = scOk && mValid && ((addr / LB) == mLine) && !kill;
    eBus  = (lrOk || scOk) && (miss || !cach);
    eAttr = eBus && !cach;
    if (lrOk) begin mValid = 1; mLine = addr / LB; end
    else if (scOk || kill) mValid = 0;

    reqValid = (op != NOP); reqOp = 3'(op); reqSize = 2'(size); reqAddr = AW'(addr);
    reqLittle = le; reqCacheable = cach; reqMiss = miss; cancelA = ca; cancelB = cb;
    snoopValid = sv; snoopWrite = sw; snoopFromComm = sc; snoopAddr = AW'(saddr);
    @(posedge clk); #1;
    idle();
    check(tag, "alignExc", alignExc, fault);
    check(tag, "scDone", scDone, eDone);
    check(tag, "scSuccess", scSuccess, ePass);
    check(tag, "busReq", busReq, eBus);
    check(tag, "busAttr", busAttr, eAttr);
    check(tag, "resvValid", resvValid, mValid);
  endtask

  task automatic simple(input string tag, input int op, input int addr);
    doOp(tag, op, 2, addr, 0, 1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "resvValid", resvValid, 0);
    check("R1", "scDone", scDone, 0);
    check("R1", "scSuccess", scSuccess, 0);
    check("R1", "alignExc", alignExc, 0);
    check("R1", "busReq", busReq, 0);
    check("R1", "busAttr", busAttr, 0);
    rstN = 1;
    @(posedge clk); #1;

    // R2 / R3 / R4: load-reserve at every address, store on the same or next line
    for (int a = 0; a < 256; a++) begin
      simple((a % 4) != 0 ? "R3" : "R2", 2, a);
      simple("R4", 3, (a % 2 == 0) ? (a & 'hFC) : (((a + 16) % 256) & 'hFC));
      if (a % 8 == 3) simple("R3", 3, a);
    end
    // R2: a second load-reserve replaces the first
    simple("R2", 2, 'h40);
    simple("R2", 2, 'h80);
    simple("R4", 3, 'h44);
    simple("R2", 2, 'h80);
    simple("R4", 3, 'h88);

    // R8: plain loads and stores, every size, offset and byte order
    for (int le = 0; le < 2; le++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < 16; a++)
          doOp("R8", a % 2, sz, a + 32, le[0], 1, 0, 0, 0, 0, 0, 0, 0);

    // R9: multiple/string accesses
    for (int le = 0; le < 2; le++)
      for (int a = 0; a < 8; a++)
        doOp("R9", 4, 2, a * 4 + (a % 2), le[0], 1, 0, 0, 0, 0, 0, 0, 0);

    // R5: cancel pins, alone and against a load-reserve
    simple("R5", 2, 'h30);
    doOp("R5", NOP, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    simple("R5", 2, 'h30);
    doOp("R5", NOP, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0);
    doOp("R5", 2, 2, 'h50, 0, 1, 0, 1, 1, 0, 0, 0, 0);
    simple("R5", 3, 'h54);

    // R6: snoop traffic that must not clear, then one that must
    simple("R6", 2, 'hA0);
    doOp("R6", NOP, 0, 0, 0, 1, 0, 0, 0, 1, 0, 1, 'hA4);
    doOp("R6", NOP, 0, 0, 0, 1, 0, 0, 0, 1, 1, 0, 'hA4);
    doOp("R6", NOP, 0, 0, 0, 1, 0, 0, 0, 1, 1, 1, 'hB0);
    doOp("R6", NOP, 0, 0, 0, 1, 0, 0, 0, 0, 1, 1, 'hA0);
    simple("R6", 3, 'hA8);
    simple("R6", 2, 'hA0);
    doOp("R6", NOP, 0, 0, 0, 1, 0, 0, 0, 1, 1, 1, 'hAC);
    simple("R6", 3, 'hA0);

    // R7: kill in the same cycle as the store
    simple("R7", 2, 'h20);
    doOp("R7", 3, 2, 'h20, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    simple("R7", 2, 'h20);
    doOp("R7", 3, 2, 'h24, 0, 1, 0, 0, 0, 1, 1, 1, 'h28);
    simple("R7", 2, 'h20);
    doOp("R7", 3, 2, 'h24, 0, 1, 0, 0, 0, 1, 1, 1, 'h60);

    // R10: bus request and attribute over cacheable/miss
    for (int c = 0; c < 2; c++)
      for (int m = 0; m < 2; m++) begin
        doOp("R10", 2, 2, 'h70, 0, c[0], m[0], 0, 0, 0, 0, 0, 0);
        doOp("R10", 3, 2, 'h70, 0, c[0], m[0], 0, 0, 0, 0, 0, 0);
        doOp("R10", 0, 2, 'h70, 0, c[0], m[0], 0, 0, 0, 0, 0, 0);
        doOp("R10", 2, 2, 'h71, 0, c[0], m[0], 0, 0, 0, 0, 0, 0);
      end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d exp %0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule